// File: doc/BRIEF.md
# Fail-First Vector Length Truncation Unit

This block follows a vector loop one element at a time and works out the vector length that the loop ends up with. A `start` pulse loads the configuration: the starting length, the mode, the condition-bit selector, the invert flag, the inclusive-length flag, the record flag and the condition-only flag. The issuer then presents elements in ascending index order. Each element carries its index, a 4-bit condition field and a fault flag. The block reduces the length on the first qualifying failure and raises `stop` so that the issuer drops the elements that remain.

There are two modes. In memory mode (`mode_cond` = 0) the fault flags decide. A fault on the first element becomes an ordinary trap request. A fault on any later element truncates the length, and in this mode the length can never reach zero. In condition mode (`mode_cond` = 1) the block tests one chosen bit of each condition field against the invert flag. A failed test truncates the length either before or after the failing element, and in this mode a length of zero is a legal result. For each element the block also returns result-write and condition-write enables.

Top module: `vl_failfirst`

## Requirements
- R1: After reset, `vl_out` is 0 and `stop` and `trap` are both low.
- R2: A `start` pulse sets `vl_out` to `vl_in` and clears `stop` and `trap` on the next clock edge. The captured `vl_in` also becomes the limit: only elements whose index is below it are considered.
- R3: In memory mode, a fault on the element with index 0 raises `trap` on the next edge. `vl_out` and `stop` do not change.
- R4: In memory mode, a fault on an element with index k ≥ 1 sets `vl_out` to k and raises `stop` on the next edge, so `vl_out` never becomes 0 through a fault.
- R5: In condition mode the tested bit is `elem_cond[bit_sel]`, where bit 0 is the LSB. The test fails when that bit equals `inv`. A failure at index k with the inclusive flag off sets `vl_out` to k and raises `stop`.
- R6: The inclusive flag `vli` takes effect only when `rc` is 0. In that case a failure at index k sets `vl_out` to k+1. When `rc` is 1, `vli` is ignored and the new length is k.
- R7: In condition mode, a failure on element 0 with the inclusive flag off sets `vl_out` to 0.
- R8: If no element fails, `vl_out` keeps the loaded length and `stop` stays low. In condition mode the fault flags have no effect.
- R9: In condition mode with `rc1` set, `data_we` stays low for every element, while `cond_we` is high for every element that is considered.
- R10: `data_we` is high for each considered element that passes. It is also high for an element that fails in condition mode when the inclusive flag is in effect. It is low for a faulting element in memory mode and for a failing element that is excluded.
- R11: After the first failure or trap, later elements are ignored until the next `start`. Elements whose index is at or above the loaded length are always ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Loads the configuration and begins a loop |
| vl_in | input | 7 | Starting vector length |
| mode_cond | input | 1 | 0 = memory fault mode, 1 = condition mode |
| bit_sel | input | 2 | Index of the condition bit to test |
| inv | input | 1 | Value of the tested bit that counts as a failure |
| vli | input | 1 | Keep the failing element in the new length |
| rc | input | 1 | Record flag; when set it disables `vli` |
| rc1 | input | 1 | Condition-only: suppresses result writes in condition mode |
| elem_valid | input | 1 | An element is presented this cycle |
| elem_idx | input | 7 | Element index |
| elem_cond | input | 4 | Element condition field |
| elem_fault | input | 1 | Element raised an access fault |
| vl_out | output | 7 | Current or truncated vector length |
| stop | output | 1 | Discard the remaining elements |
| trap | output | 1 | Raise an ordinary exception |
| data_we | output | 1 | Result write enable for the presented element |
| cond_we | output | 1 | Condition write enable for the presented element |

## Verification
The three registered results `vl_out`, `stop` and `trap` change on the clock edge that captures an element or a `start`. The bench drives inputs on the falling edge and reads these results on the next falling edge, after the capture. The write enables `data_we` and `cond_we` are combinational from the presented element and the locked state. The bench therefore checks them a short delay after driving each element, before the capturing edge. The final length is checked only after the whole stream and one out-of-range element have been applied, so that no element reaching the block after the first failure can change it.

// File: rtl/vl_failfirst.sv
module vl_failfirst #(
  parameter int MAXVL = 64,
  localparam int VLW = $clog2(MAXVL + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [VLW-1:0] vl_in,
  input  logic           mode_cond,
  input  logic [1:0]     bit_sel,
  input  logic           inv,
  input  logic           vli,
  input  logic           rc,
  input  logic           rc1,
  input  logic           elem_valid,
  input  logic [VLW-1:0] elem_idx,
  input  logic [3:0]     elem_cond,
  input  logic           elem_fault,
  output logic [VLW-1:0] vl_out,
  output logic           stop,
  output logic           trap,
  output logic           data_we,
  output logic           cond_we
);

  logic           active_q, cond_q, inv_q, incl_q, rc1_q;
  logic [1:0]     sel_q;
  logic [VLW-1:0] lim_q;

  wire live      = active_q & ~stop & ~trap;
  wire hit       = elem_valid & live & (elem_idx < lim_q);
  wire tbit      = elem_cond[sel_q];
  wire cfail     = cond_q & (tbit == inv_q);
  wire mfault    = ~cond_q & elem_fault;
  wire first_el  = (elem_idx == '0);

  assign data_we = hit & ~(cond_q & rc1_q) & ~mfault & ~(cfail & ~incl_q);
  assign cond_we = hit & cond_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cond_q   <= 1'b0;
      inv_q    <= 1'b0;
      incl_q   <= 1'b0;
      rc1_q    <= 1'b0;
      sel_q    <= '0;
      lim_q    <= '0;
      vl_out   <= '0;
      stop     <= 1'b0;
      trap     <= 1'b0;
    end else if (start) begin
      active_q <= 1'b1;
      cond_q   <= mode_cond;
      inv_q    <= inv;
      incl_q   <= vli & ~rc;
      rc1_q    <= rc1;
      sel_q    <= bit_sel;
      lim_q    <= vl_in;
      vl_out   <= vl_in;
      stop     <= 1'b0;
      trap     <= 1'b0;
    end else if (hit) begin
      if (mfault) begin
        if (first_el) trap <= 1'b1;
        else begin
          vl_out <= elem_idx;
          stop   <= 1'b1;
        end
      end else if (cfail) begin
        vl_out <= incl_q ? elem_idx + 1'b1 : elem_idx;
        stop   <= 1'b1;
      end
    end
  end

  p_first_fault_trap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && elem_valid && !mode_cond && elem_fault && elem_idx == '0 && live && lim_q != '0 && !cond_q)
      |=> (trap && $stable(vl_out)));

  p_mem_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && hit && mfault && !first_el) |=> (stop && vl_out != '0));

  p_inclusive_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && hit && cfail && incl_q) |=> (vl_out == $past(elem_idx) + 1'b1));

  p_rc1_nodata_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && cond_q && rc1_q) |-> !data_we);

  p_locked_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((stop || trap) && !start) |=> ($stable(vl_out) && $stable(trap)));

endmodule

// File: tb/test_vl_failfirst.sv
module test_vl_failfirst;
  localparam int VLW = 7;
  localparam logic [6:0] NONE = 7'd127;

  typedef struct packed {
    logic       m;
    logic [6:0] vl;
    logic [1:0] sel;
    logic       iv;
    logic       incl;
    logic       rcf;
    logic [6:0] fk;
    logic [6:0] evl;
    logic       etrap;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 7'd8, 2'd0, 1'b0, 1'b0, 1'b0, 7'd0,  7'd8, 1'b1},
    '{1'b0, 7'd8, 2'd0, 1'b0, 1'b0, 1'b0, 7'd3,  7'd3, 1'b0},
    '{1'b0, 7'd8, 2'd0, 1'b0, 1'b0, 1'b0, NONE,  7'd8, 1'b0},
    '{1'b0, 7'd5, 2'd0, 1'b0, 1'b1, 1'b0, 7'd4,  7'd4, 1'b0},
    '{1'b1, 7'd8, 2'd2, 1'b0, 1'b0, 1'b0, 7'd5,  7'd5, 1'b0},
    '{1'b1, 7'd8, 2'd1, 1'b1, 1'b1, 1'b0, 7'd5,  7'd6, 1'b0},
    '{1'b1, 7'd8, 2'd3, 1'b1, 1'b1, 1'b1, 7'd5,  7'd5, 1'b0},
    '{1'b1, 7'd8, 2'd0, 1'b0, 1'b0, 1'b0, 7'd0,  7'd0, 1'b0},
    '{1'b1, 7'd8, 2'd0, 1'b1, 1'b1, 1'b0, 7'd0,  7'd1, 1'b0},
    '{1'b1, 7'd6, 2'd2, 1'b0, 1'b0, 1'b0, NONE,  7'd6, 1'b0},
    '{1'b1, 7'd6, 2'd3, 1'b0, 1'b1, 1'b0, 7'd5,  7'd6, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [VLW-1:0] vl_in = '0, elem_idx = '0, vl_out;
  logic mode_cond = 1'b0, inv = 1'b0, vli = 1'b0, rc = 1'b0, rc1 = 1'b0;
  logic [1:0] bit_sel = '0;
  logic elem_valid = 1'b0, elem_fault = 1'b0;
  logic [3:0] elem_cond = '0;
  logic stop, trap, data_we, cond_we;
  int nchk = 0, nfail = 0, cyc = 0;

  always #4 clk = ~clk;

  vl_failfirst i_vl_failfirst (
    .clk, .rst_n, .start, .vl_in, .mode_cond, .bit_sel, .inv, .vli, .rc, .rc1,
    .elem_valid, .elem_idx, .elem_cond, .elem_fault,
    .vl_out, .stop, .trap, .data_we, .cond_we
  );

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      nfail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 50000);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  function automatic logic [3:0] mkcond(input logic [1:0] s, input logic b);
    logic [3:0] c;
    c = {4{~b}};
    c[s] = b;
    return c;
  endfunction

  task automatic launch(input logic m, input logic [6:0] l, input logic [1:0] s,
                        input logic iv, input logic in, input logic r, input logic r1);
    @(negedge clk);
    start = 1'b1; vl_in = l; mode_cond = m; bit_sel = s; inv = iv; vli = in; rc = r; rc1 = r1;
    @(negedge clk);
    start = 1'b0;
    chk("R2 vl_out after start", vl_out, l);
    chk("R2 stop cleared", stop, 0);
    chk("R2 trap cleared", trap, 0);
  endtask

  initial begin
    #20;
    chk("R1 reset vl_out", vl_out, 0);
    chk("R1 reset stop", stop, 0);
    chk("R1 reset trap", trap, 0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      vec_t t;
      t = TBL[v];
      launch(t.m, t.vl, t.sel, t.iv, t.incl, t.rcf, 1'b0);
      for (int k = 0; k <= t.vl; k++) begin
        logic failing, expd, expc, lockd, inr;
        inr     = (k < t.vl);
        failing = (k == t.fk) || !inr;
        lockd   = (t.fk != NONE) && (k > t.fk);
        elem_valid = 1'b1;
        elem_idx   = 7'(k);
        if (t.m) begin
          elem_cond  = mkcond(t.sel, failing ? t.iv : ~t.iv);
          elem_fault = 1'b1;
        end else begin
          elem_cond  = 4'(k);
          elem_fault = failing;
        end
        #1;
        if (!inr || lockd) begin expd = 1'b0; expc = 1'b0; end
        else if (k == t.fk) begin
          expd = t.m ? (t.incl & ~t.rcf) : 1'b0;
          expc = t.m;
        end else begin expd = 1'b1; expc = t.m; end
        chk($sformatf("R10 data_we vec %0d elem %0d", v, k), data_we, expd);
        chk($sformatf("R9 cond_we vec %0d elem %0d", v, k), cond_we, expc);
        @(negedge clk);
      end
      elem_valid = 1'b0; elem_fault = 1'b0;
      @(negedge clk);
      // R4 R5 R6 R7 R8 R11 final length; R3 trap
      chk($sformatf("R5/R6/R7/R8 vl_out vec %0d", v), vl_out, t.evl);
      chk($sformatf("R3 trap vec %0d", v), trap, t.etrap);
      chk($sformatf("R11 stop vec %0d", v), stop, (t.fk != NONE) && !t.etrap);
    end

    // R9: condition-only option suppresses result writes
    launch(1'b1, 7'd4, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1);
    for (int k = 0; k < 4; k++) begin
      elem_valid = 1'b1; elem_idx = 7'(k); elem_cond = mkcond(2'd1, 1'b1); elem_fault = 1'b0;
      #1;
      chk("R9 rc1 data_we low", data_we, 0);
      chk("R9 rc1 cond_we high", cond_we, 1);
      @(negedge clk);
    end
    elem_valid = 1'b0;
    @(negedge clk);
    chk("R8 rc1 run length kept", vl_out, 4);
    chk("R8 rc1 run no stop", stop, 0);

    // R11: lock persists until a new start
    launch(1'b0, 7'd6, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    elem_valid = 1'b1; elem_idx = 7'd2; elem_fault = 1'b1;
    @(negedge clk);
    elem_idx = 7'd1;
    @(negedge clk);
    elem_valid = 1'b0; elem_fault = 1'b0;
    @(negedge clk);
    chk("R11 lock keeps first truncation", vl_out, 2);
    launch(1'b0, 7'd6, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R11 restart clears stop", stop, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule